// File: doc/BRIEF.md
# Sector Erase Collector with Acceptance Window

This block sits between the write port of a seven-sector boot-block flash and its erase engine. It follows the six-write unlock and setup sequence that requests a sector erase. It then marks the addressed sector in a seven-bit selection mask and opens an acceptance window that lasts a fixed number of clock cycles. Each further sector-erase command (data 0x30) that arrives while the window is open adds its sector to the mask and restarts the window. This lets several sectors, in any order, be merged into one erase.

When the window runs out with no write in its last cycle, the block removes protected sectors from the mask. If any sector is left, it raises a one-cycle start pulse with the final mask. If none is left, it raises a one-cycle pulse that reports immediate completion. After a start, the block ignores all writes until the erase engine signals that it is done. A strap selects how the five high address bits map to sector numbers, either with the small sectors at the top of the address space or at the bottom.

Top module: `erase_sector_collector`

## Requirements
- R1: After a synchronous reset, `busy`, `erase_start` and `erase_none` are low and `erase_mask` is zero.
- R2: When six consecutive writes arrive as 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, and then 0x30 at a sector address, a window opens. Only the low 11 address bits are compared against 0x555 and 0x2AA. `busy` rises in the cycle after the clock edge that samples the sixth write, and exactly one sector is marked at that point.
- R3: A write that does not match the next expected step of the sequence returns the block to idle, and no window opens.
- R4: The window closes on the WINDOW_CYC-th clock edge after the last accepted command, provided none of the intervening edges sampled a write. `busy` falls at that same edge. A sector command that arrives after the window has closed is not collected.
- R5: While the window is open, a write of 0x30 to any address adds that address's sector to the mask and restarts the window. All seven sectors can be collected, in any order.
- R6: When the window closes, `erase_start` pulses for exactly one cycle. `erase_mask` then equals the collected mask with the sectors set in `prot_mask` cleared. `erase_mask` holds that value until the next start. Bit i of the mask stands for sector i, and sectors are numbered in ascending address order.
- R7: With `boot_top`=1, the sectors by address bits 17..13 are: 0 = 00xxx, 1 = 01xxx, 2 = 10xxx, 3 = 110xx, 4 = 11100, 5 = 11101, 6 = 1111x.
- R8: With `boot_top`=0, the sectors by address bits 17..13 are: 0 = 0000x, 1 = 00010, 2 = 00011, 3 = 001xx, 4 = 01xxx, 5 = 10xxx, 6 = 11xxx.
- R9: A write with data other than 0x30 while the window is open clears the mask and returns the block to idle. Neither `erase_start` nor `erase_none` pulses.
- R10: If every collected sector is protected, `erase_none` pulses for one cycle instead of `erase_start`, and `erase_mask` keeps its previous value.
- R11: After a start, all writes are ignored until `erase_done` is high at a clock edge. After that edge the block is idle again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_top | input | 1 | Layout strap: 1 puts the small sectors at the top of the address space |
| prot_mask | input | 7 | Per-sector protection; a set bit drops that sector from the erase |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 18 | Byte address of the write |
| wr_data | input | 8 | Data of the write |
| erase_done | input | 1 | Erase engine reports that the erase is complete |
| busy | output | 1 | High while the acceptance window is open |
| erase_start | output | 1 | One-cycle erase launch pulse |
| erase_mask | output | 7 | Final sector mask, valid with and after `erase_start` |
| erase_none | output | 1 | One-cycle pulse: nothing left to erase after protection |

## Verification
`busy` is due one edge after the write that completes the sequence. An abort takes effect one edge after the offending write. `erase_start` or `erase_none` is due on the WINDOW_CYC-th edge after the last accepted command, with `erase_mask` updated at that same edge. The bench drives its inputs and samples the outputs on the falling clock edge, so every registered result is read half a cycle after the rising edge that produces it. A behavioural model, advanced on each rising edge from the same inputs, supplies the expected value for every output in every cycle. Directed checks then confirm the mask at each pulse and confirm that writes made while the block ignores them leave it unchanged.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int NSEC   = 7;
  localparam int HI_W   = 5;
  localparam int LO_W   = 11;
  localparam int IDX_W  = $clog2(NSEC);

  localparam logic [LO_W-1:0] ADDR_ONE = 11'h555;
  localparam logic [LO_W-1:0] ADDR_TWO = 11'h2AA;
  localparam logic [7:0] D_UNLK1 = 8'hAA;
  localparam logic [7:0] D_UNLK2 = 8'h55;
  localparam logic [7:0] D_SETUP = 8'h80;
  localparam logic [7:0] D_SECT  = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_SETUP, ST_U4, ST_U5, ST_COLLECT, ST_ERASE
  } esc_state_t;

  // small sectors at the top of the address space
  function automatic logic [IDX_W-1:0] idx_top(input logic [HI_W-1:0] h);
    if (h[4:3] != 2'b11) return {1'b0, h[4:3]};
    else if (!h[2])      return 3'd3;
    else if (h[1])       return 3'd6;
    else                 return h[0] ? 3'd5 : 3'd4;
  endfunction

  // small sectors at the bottom of the address space
  function automatic logic [IDX_W-1:0] idx_bot(input logic [HI_W-1:0] h);
    if (h[4:3] != 2'b00) return 3'd3 + {1'b0, h[4:3]};
    else if (h[2])       return 3'd3;
    else if (!h[1])      return 3'd0;
    else                 return h[0] ? 3'd2 : 3'd1;
  endfunction
endpackage

// File: rtl/esc_sector_map.sv
module esc_sector_map
  import esc_pkg::*;
(
  input  logic            boot_top,
  input  logic [HI_W-1:0] hi_addr,
  output logic [NSEC-1:0] sec_bit
);
  logic [IDX_W-1:0] idx;

  always_comb idx = boot_top ? idx_top(hi_addr) : idx_bot(hi_addr);

  for (genvar g = 0; g < NSEC; g++) begin : g_onehot
    assign sec_bit[g] = (idx == IDX_W'(g));
  end
endmodule

// File: rtl/esc_window_timer.sv
module esc_window_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] TOP = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= TOP;
    else if (run && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign expire = run && (cnt == '0);
endmodule

// File: rtl/erase_sector_collector.sv
module erase_sector_collector
  import esc_pkg::*;
#(
  parameter int WINDOW_CYC = 5000,
  parameter int AW         = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_top,
  input  logic [6:0]    prot_mask,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          erase_done,
  output logic          busy,
  output logic          erase_start,
  output logic [6:0]    erase_mask,
  output logic          erase_none
);
  esc_state_t      state;
  logic [NSEC-1:0] col_mask;
  logic [NSEC-1:0] sec_bit;
  logic [NSEC-1:0] final_mask;
  logic [LO_W-1:0] lo;
  logic            w_u1, w_u2, w_setup, w_cmd;
  logic            t_load, t_run, t_exp;

  assign lo      = wr_addr[LO_W-1:0];
  assign w_u1    = (lo == ADDR_ONE) && (wr_data == D_UNLK1);
  assign w_u2    = (lo == ADDR_TWO) && (wr_data == D_UNLK2);
  assign w_setup = (lo == ADDR_ONE) && (wr_data == D_SETUP);
  assign w_cmd   = (wr_data == D_SECT);

  esc_sector_map u_map (
    .boot_top (boot_top),
    .hi_addr  (wr_addr[AW-1:AW-HI_W]),
    .sec_bit  (sec_bit)
  );

  assign t_load = wr_en && w_cmd && (state == ST_U5 || state == ST_COLLECT);
  assign t_run  = (state == ST_COLLECT) && !wr_en;

  esc_window_timer #(.CYCLES(WINDOW_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (t_load),
    .run    (t_run),
    .expire (t_exp)
  );

  assign final_mask = col_mask & ~prot_mask;
  assign busy       = (state == ST_COLLECT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      col_mask    <= '0;
      erase_start <= 1'b0;
      erase_none  <= 1'b0;
      erase_mask  <= '0;
    end else begin
      erase_start <= 1'b0;
      erase_none  <= 1'b0;
      unique case (state)
        ST_IDLE:  if (wr_en) state <= w_u1    ? ST_U1    : ST_IDLE;
        ST_U1:    if (wr_en) state <= w_u2    ? ST_U2    : ST_IDLE;
        ST_U2:    if (wr_en) state <= w_setup ? ST_SETUP : ST_IDLE;
        ST_SETUP: if (wr_en) state <= w_u1    ? ST_U4    : ST_IDLE;
        ST_U4:    if (wr_en) state <= w_u2    ? ST_U5    : ST_IDLE;
        ST_U5: begin
          if (wr_en) begin
            if (w_cmd) begin
              state    <= ST_COLLECT;
              col_mask <= sec_bit;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_COLLECT: begin
          if (wr_en) begin
            if (w_cmd) col_mask <= col_mask | sec_bit;
            else begin
              state    <= ST_IDLE;
              col_mask <= '0;
            end
          end else if (t_exp) begin
            col_mask <= '0;
            if (|final_mask) begin
              erase_start <= 1'b1;
              erase_mask  <= final_mask;
              state       <= ST_ERASE;
            end else begin
              erase_none <= 1'b1;
              state      <= ST_IDLE;
            end
          end
        end
        ST_ERASE: if (erase_done) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/esc_checker.sv
module esc_checker (
  input logic       clk,
  input logic       rst,
  input logic [6:0] prot_mask,
  input logic       busy,
  input logic       erase_start,
  input logic       erase_none,
  input logic [6:0] erase_mask,
  input logic [6:0] col_mask
);
  // R2
  open_single_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $countones(col_mask) == 1);

  // R5
  mask_grows_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((col_mask & $past(col_mask)) == $past(col_mask)));

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);

  // R6
  start_unprot_chk: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> ((erase_mask & $past(prot_mask)) == 7'd0) && (erase_mask != 7'd0));

  // R10
  none_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(erase_start && erase_none));

  // R11
  start_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> !busy);
endmodule

bind erase_sector_collector esc_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .prot_mask   (prot_mask),
  .busy        (busy),
  .erase_start (erase_start),
  .erase_none  (erase_none),
  .erase_mask  (erase_mask),
  .col_mask    (col_mask)
);

// File: tb/erase_sector_collector_bench.sv
module erase_sector_collector_bench;
  localparam int W = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_top = 1'b1;
  logic [6:0]  prot_mask = '0;
  logic        wr_en = 1'b0;
  logic [17:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        erase_done = 1'b0;
  logic        busy, erase_start, erase_none;
  logic [6:0]  erase_mask;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  erase_sector_collector #(.WINDOW_CYC(W)) u_erase_sector_collector (
    .clk(clk), .rst(rst), .boot_top(boot_top), .prot_mask(prot_mask),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_done(erase_done), .busy(busy), .erase_start(erase_start),
    .erase_mask(erase_mask), .erase_none(erase_none)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // sector bit from address ranges
  function automatic logic [6:0] sbit(input logic top, input logic [17:0] a);
    int s;
    if (top) begin
      if (a < 18'h30000) s = a / 18'h10000;
      else if (a < 18'h38000) s = 3;
      else if (a < 18'h3A000) s = 4;
      else if (a < 18'h3C000) s = 5;
      else s = 6;
    end else begin
      if (a < 18'h04000) s = 0;
      else if (a < 18'h06000) s = 1;
      else if (a < 18'h08000) s = 2;
      else if (a < 18'h10000) s = 3;
      else s = 3 + a / 18'h10000;
    end
    return 7'(1 << s);
  endfunction

  // behavioural reference model
  int         m_ph = 0;
  int         m_cnt = 0;
  logic [6:0] m_mask = '0, m_emask = '0, m_f;
  bit         m_start = 0, m_none = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ph = 0; m_mask = '0; m_emask = '0; m_start = 0; m_none = 0; m_cnt = 0;
    end else begin
      m_start = 0; m_none = 0;
      if (m_ph <= 5) begin
        if (wr_en) begin
          bit ok;
          case (m_ph)
            0, 3: ok = wr_addr[10:0] == 11'h555 && wr_data == 8'hAA;
            1, 4: ok = wr_addr[10:0] == 11'h2AA && wr_data == 8'h55;
            2:    ok = wr_addr[10:0] == 11'h555 && wr_data == 8'h80;
            default: ok = wr_data == 8'h30;
          endcase
          if (!ok) m_ph = 0;
          else if (m_ph == 5) begin m_ph = 6; m_mask = sbit(boot_top, wr_addr); m_cnt = W; end
          else m_ph++;
        end
      end else if (m_ph == 6) begin
        if (wr_en) begin
          if (wr_data == 8'h30) begin m_mask |= sbit(boot_top, wr_addr); m_cnt = W; end
          else begin m_ph = 0; m_mask = '0; end
        end else begin
          m_cnt--;
          if (m_cnt == 0) begin
            m_f = m_mask & ~prot_mask;
            m_mask = '0;
            if (m_f != 0) begin m_start = 1; m_emask = m_f; m_ph = 7; end
            else begin m_none = 1; m_ph = 0; end
          end
        end
      end else if (erase_done) m_ph = 0;
    end
  end

  always @(negedge clk) if (cyc >= 2) begin
    check(busy == (m_ph == 6), "R4 busy", busy, m_ph == 6);
    check(erase_start == m_start, "R6 start", erase_start, m_start);
    check(erase_none == m_none, "R10 none", erase_none, m_none);
    check(erase_mask == m_emask, "R6 mask", erase_mask, m_emask);
  end

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic seq(input logic [17:0] sa);
    wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h00555, 8'h80);
    wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(sa, 8'h30);
  endtask

  // waits for a pulse; kind 1 = start, 2 = none, 0 = nothing
  task automatic wait_pulse(output int kind, output logic [6:0] m);
    kind = 0; m = '0;
    for (int i = 0; i < W + 6; i++) begin
      if (erase_start) begin kind = 1; m = erase_mask; break; end
      if (erase_none)  begin kind = 2; break; end
      @(negedge clk);
    end
  endtask

  task automatic finish_erase();
    @(negedge clk); erase_done = 1; @(negedge clk); erase_done = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k;
    logic [6:0] m;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!busy && !erase_start && !erase_none && erase_mask == 0, "R1 reset", erase_mask, 0);

    // R2 R7 single sector, top layout
    boot_top = 1;
    seq(18'h3A000);
    check(busy, "R2 busy after sequence", busy, 1);
    wait_pulse(k, m);
    check(k == 1 && m == 7'b0100000, "R7 sector 5 top", m, 7'b0100000);
    finish_erase();

    // R5 R7 all seven in scrambled order
    seq(18'h3C000);
    wr(18'h00000, 8'h30); repeat (W - 3) @(negedge clk);
    wr(18'h38000, 8'h30); wr(18'h30000, 8'h30); wr(18'h10000, 8'h30);
    wr(18'h2FFFF, 8'h30); wr(18'h3BFFF, 8'h30);
    check(busy, "R5 window restarted", busy, 1);
    wait_pulse(k, m);
    check(k == 1 && m == 7'h7F, "R5 all sectors", m, 7'h7F);
    finish_erase();

    // R8 bottom layout
    boot_top = 0;
    seq(18'h06000);
    wait_pulse(k, m);
    check(k == 1 && m == 7'b0000100, "R8 sector 2 bottom", m, 7'b0000100);
    finish_erase();
    seq(18'h04000); wr(18'h3FFFF, 8'h30); wr(18'h03FFF, 8'h30); wr(18'h08000, 8'h30);
    wait_pulse(k, m);
    check(k == 1 && m == 7'b1001011, "R8 bottom multi", m, 7'b1001011);
    finish_erase();

    // R6 protection filter
    prot_mask = 7'b0000010;
    seq(18'h04000); wr(18'h08000, 8'h30);
    wait_pulse(k, m);
    check(k == 1 && m == 7'b0001000, "R6 protected dropped", m, 7'b0001000);
    finish_erase();

    // R10 everything protected
    seq(18'h05000);
    wait_pulse(k, m);
    check(k == 2, "R10 none pulse", k, 2);
    check(erase_mask == 7'b0001000, "R10 mask kept", erase_mask, 7'b0001000);
    prot_mask = '0;

    // R9 abort in window
    seq(18'h20000); wr(18'h00000, 8'hF0);
    check(!busy, "R9 abort closes", busy, 0);
    wait_pulse(k, m);
    check(k == 0, "R9 no pulse", k, 0);

    // R3 broken sequence
    wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h00555, 8'h90);
    wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h10000, 8'h30);
    check(!busy, "R3 no window", busy, 0);
    wait_pulse(k, m);
    check(k == 0, "R3 no pulse", k, 0);

    // R4 late command is not collected
    seq(18'h10000);
    repeat (W + 2) @(negedge clk);
    wr(18'h20000, 8'h30);
    check(erase_mask == 7'b0010000, "R4 late command lost", erase_mask, 7'b0010000);

    // R11 writes ignored while erasing
    seq(18'h30000);
    check(!busy, "R11 ignored during erase", busy, 0);
    finish_erase();
    wait_pulse(k, m);
    check(k == 0 && erase_mask == 7'b0010000, "R11 idle after done", erase_mask, 7'b0010000);
    seq(18'h30000);
    wait_pulse(k, m);
    check(k == 1 && m == 7'b1000000, "R11 accepts after done", m, 7'b1000000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule